// File: doc/BRIEF.md
# Split Dual-Half Interval Timer

A memory-mapped up-counting timer that software configures over a plain 32-bit register bus. Its 64-bit count can run as a single wide timer or be split into two independent 32-bit halves, a lower and an upper one. Each half has its own count register, period register, 2-bit enable field and run bit, and drives its own interrupt line. Counting advances only on clock cycles where the `tick` clock-enable input is high.

Software picks the arrangement through a timer-arrangement field. It releases each half with a run bit, and it arms each half with an enable field as one-shot or periodic. When a running count equals its period, the count returns to zero and the matching interrupt line pulses for one clock. A one-shot half also disarms itself. A period of all ones turns a periodic half into a free-running counter that interrupts on each wrap.

Top module: `split_timer`

## Requirements
- R1: After reset every count, period and control register reads zero and both interrupt outputs are low. Offset 0x00 reads the constant `ID_VALUE`, which is nonzero.
- R2: The register offsets are: lower count 0x10, upper count 0x14, lower period 0x18, upper period 0x1C, enable control 0x20 and arrangement control 0x24. Enable control holds the lower-half enable field in bits 7:6 and the upper-half enable field in bits 23:22. Arrangement control holds the lower run bit in bit 0, the upper run bit in bit 1 and the arrangement field in bits 3:2. Unused bits read zero. A write takes effect at the next clock edge, and reads are combinational.
- R3: Writes to any other offset, 0x28 and 0x04 included, change no state. Reads from those offsets return zero.
- R4: A half advances by one at each clock edge where `tick` is high, its run bit is 1 and its enable field is nonzero. With the enable field at 0 the count holds its value.
- R5: While a half's run bit is 0, its count is forced to zero and bus writes to that count have no effect.
- R6: With enable value 2 (periodic; value 3 acts the same way), a ticking edge at which count equals period sets the count to 0 and drives that half's interrupt high for exactly the next clock cycle. With the period set to all ones, the count wraps from all ones to 0.
- R7: With enable value 1 (one-shot), a match acts as in R6, and in addition the half's enable field is cleared to 0, so the count then stays at 0.
- R8: When bit 0 of the arrangement field is 1 (values 1 and 3), the two halves run independently and each signals on its own interrupt line.
- R9: When bit 0 of the arrangement field is 0 (values 0 and 2), the halves form one 64-bit counter. The lower enable field controls the whole counter and the upper enable field is ignored. Both run bits must be 1 for it to count. The lower half carries into the upper half when the lower half is all ones. A match needs both halves equal to their periods and pulses only the lower interrupt line, while the upper line stays low.
- R10: A bus write to a running count takes priority over counting and wrapping at the same edge. The next ticking edge then continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, sampled on every clock edge |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lo | output | 1 | Lower-half (or 64-bit) match pulse |
| irq_hi | output | 1 | Upper-half match pulse, split arrangement only |

## Verification
Every result has its own latency. A register write is visible on the read port one edge after the strobe. A count moves one step per ticking edge. A match interrupt is high during the single cycle that follows the edge where count and period met, and that same edge zeroes the count and clears a one-shot field. The bench drives every input on the falling edge and reads back on a later falling edge. This way each sample falls after a known number of rising edges, and the expected count can be calculated as that number modulo the period plus one. Carry, wrap and priority cases each start from a count loaded a few steps short of the boundary, so the boundary edge can be identified exactly.

// File: rtl/stmr_pkg.sv
package stmr_pkg;
    // Width of one counting half
    localparam int HALF_W = 32;

    // Register byte offsets
    localparam logic [7:0] OFF_ID     = 8'h00;
    localparam logic [7:0] OFF_CNT_LO = 8'h10;
    localparam logic [7:0] OFF_CNT_HI = 8'h14;
    localparam logic [7:0] OFF_PRD_LO = 8'h18;
    localparam logic [7:0] OFF_PRD_HI = 8'h1C;
    localparam logic [7:0] OFF_ENCTL  = 8'h20;
    localparam logic [7:0] OFF_ARRCTL = 8'h24;

    // Enable field positions inside the enable-control register
    localparam int EN_LO_POS = 6;
    localparam int EN_HI_POS = 22;

    typedef enum logic [1:0] {
        EN_OFF   = 2'd0,
        EN_ONCE  = 2'd1,
        EN_LOOP  = 2'd2,
        EN_LOOP2 = 2'd3
    } en_mode_t;

    typedef enum logic [1:0] {
        ARR_JOIN    = 2'd0,
        ARR_SPLIT   = 2'd1,
        ARR_JOIN_B  = 2'd2,
        ARR_SPLIT_B = 2'd3
    } arr_mode_t;
endpackage

// File: rtl/stmr_half.sv
// One counting half: an up-counter with a period comparator.
// Assumes the controller never requests step and wrap with conflicting
// meaning; priority is hold, then load, then wrap, then step.
module stmr_half #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         wrap,
    input  logic [W-1:0] prd,
    output logic [W-1:0] cnt,
    output logic         match,
    output logic         full
);
    // Count register update
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (hold) cnt <= '0;
        else if (load) cnt <= load_val;
        else if (wrap) cnt <= '0;
        else if (step) cnt <= cnt + W'(1);
    end

    assign match = (cnt == prd);
    assign full  = &cnt;
endmodule

// File: rtl/stmr_ctrl.sv
// Sequencing for both halves: decides step, wrap, carry, one-shot disarm
// and registers the interrupt pulses. Assumes split selects independent
// halves and otherwise the halves act as one 64-bit counter.
module stmr_ctrl
    import stmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     split,
    input  logic     run_lo,
    input  logic     run_hi,
    input  en_mode_t en_lo,
    input  en_mode_t en_hi,
    input  logic     match_lo,
    input  logic     match_hi,
    input  logic     full_lo,
    output logic     step_lo,
    output logic     step_hi,
    output logic     wrap_lo,
    output logic     wrap_hi,
    output logic     disarm_lo,
    output logic     disarm_hi,
    output logic     irq_lo,
    output logic     irq_hi
);
    logic join_act, act_lo, act_hi, join_hit;

    // Activity, step and wrap decode for both arrangements
    always_comb begin
        join_act  = run_lo && run_hi && (en_lo != EN_OFF);
        act_lo    = split ? (run_lo && en_lo != EN_OFF) : join_act;
        act_hi    = split ? (run_hi && en_hi != EN_OFF) : join_act;
        join_hit  = tick && join_act && match_lo && match_hi;
        step_lo   = tick && act_lo;
        step_hi   = split ? (tick && act_hi) : (tick && join_act && full_lo);
        wrap_lo   = split ? (tick && act_lo && match_lo) : join_hit;
        wrap_hi   = split ? (tick && act_hi && match_hi) : join_hit;
        disarm_lo = wrap_lo && (en_lo == EN_ONCE);
        disarm_hi = split && wrap_hi && (en_hi == EN_ONCE);
    end

    // One-clock interrupt pulses following a match edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            irq_lo <= wrap_lo;
            irq_hi <= split && wrap_hi;
        end
    end
endmodule

// File: rtl/split_timer.sv
// Memory-mapped dual-half timer: register file, read mux and two halves.
// Assumes a single-cycle write strobe and combinational reads.
module split_timer
    import stmr_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] ID_VALUE = 32'h7143_0201
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int NHALF = 2;

    logic [HALF_W-1:0] cnt_q  [NHALF];
    logic [HALF_W-1:0] prd_q  [NHALF];
    en_mode_t          en_q   [NHALF];
    logic [NHALF-1:0]  run_q;
    arr_mode_t         arr_q;

    logic [NHALF-1:0]  step, wrap, disarm, match, full;
    logic              wr_enctl, wr_arrctl;
    logic              split;

    assign split     = arr_q[0];
    assign wr_enctl  = bus_we && (bus_addr == ADDR_W'(OFF_ENCTL));
    assign wr_arrctl = bus_we && (bus_addr == ADDR_W'(OFF_ARRCTL));

    // Arrangement control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            arr_q <= ARR_JOIN;
        end else if (wr_arrctl) begin
            run_q <= bus_wdata[1:0];
            arr_q <= arr_mode_t'(bus_wdata[3:2]);
        end
    end

    for (genvar i = 0; i < NHALF; i++) begin : g_half
        localparam int          EPOS    = (i == 0) ? EN_LO_POS : EN_HI_POS;
        localparam logic [7:0]  CNT_OFF = OFF_CNT_LO + 8'(4 * i);
        localparam logic [7:0]  PRD_OFF = OFF_PRD_LO + 8'(4 * i);

        logic wr_cnt, wr_prd;
        assign wr_cnt = bus_we && (bus_addr == ADDR_W'(CNT_OFF));
        assign wr_prd = bus_we && (bus_addr == ADDR_W'(PRD_OFF));

        // Period register of this half
        always_ff @(posedge clk) begin
            if (!rst_n)      prd_q[i] <= '0;
            else if (wr_prd) prd_q[i] <= bus_wdata;
        end

        // Enable field: bus write wins over one-shot disarm
        always_ff @(posedge clk) begin
            if (!rst_n)         en_q[i] <= EN_OFF;
            else if (wr_enctl)  en_q[i] <= en_mode_t'(bus_wdata[EPOS +: 2]);
            else if (disarm[i]) en_q[i] <= EN_OFF;
        end

        stmr_half #(.W(HALF_W)) i_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (!run_q[i]),
            .load     (wr_cnt),
            .load_val (bus_wdata),
            .step     (step[i]),
            .wrap     (wrap[i]),
            .prd      (prd_q[i]),
            .cnt      (cnt_q[i]),
            .match    (match[i]),
            .full     (full[i])
        );
    end

    stmr_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .split     (split),
        .run_lo    (run_q[0]),
        .run_hi    (run_q[1]),
        .en_lo     (en_q[0]),
        .en_hi     (en_q[1]),
        .match_lo  (match[0]),
        .match_hi  (match[1]),
        .full_lo   (full[0]),
        .step_lo   (step[0]),
        .step_hi   (step[1]),
        .wrap_lo   (wrap[0]),
        .wrap_hi   (wrap[1]),
        .disarm_lo (disarm[0]),
        .disarm_hi (disarm[1]),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    // Read mux; unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFF_ID):     bus_rdata = ID_VALUE;
            ADDR_W'(OFF_CNT_LO): bus_rdata = cnt_q[0];
            ADDR_W'(OFF_CNT_HI): bus_rdata = cnt_q[1];
            ADDR_W'(OFF_PRD_LO): bus_rdata = prd_q[0];
            ADDR_W'(OFF_PRD_HI): bus_rdata = prd_q[1];
            ADDR_W'(OFF_ENCTL): begin
                bus_rdata[EN_LO_POS +: 2] = en_q[0];
                bus_rdata[EN_HI_POS +: 2] = en_q[1];
            end
            ADDR_W'(OFF_ARRCTL): bus_rdata[3:0] = {arr_q, run_q};
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/stmr_checker.sv
// Temporal checks on the split timer, attached through bind.
// Assumes synchronous active-low reset and the offsets of stmr_pkg.
module stmr_checker
    import stmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              split,
    input logic              run_lo,
    input logic              run_hi,
    input logic [1:0]        en_lo,
    input logic [1:0]        en_hi,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input logic [HALF_W-1:0] prd_lo,
    input logic [HALF_W-1:0] prd_hi,
    input logic              irq_lo,
    input logic              irq_hi
);
    logic wr_cnt_hi, wr_enctl;
    assign wr_cnt_hi = bus_we && (bus_addr == ADDR_W'(OFF_CNT_HI));
    assign wr_enctl  = bus_we && (bus_addr == ADDR_W'(OFF_ENCTL));

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_lo |=> (cnt_lo == '0)); // R5

    AST_DISABLED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (split && run_hi && en_hi == 2'd0 && !wr_cnt_hi) |=> $stable(cnt_hi)); // R4

    AST_JOINED_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !split |=> !irq_hi); // R9

    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> $past(tick)); // R6

    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (split && run_lo && tick && en_lo == 2'd1 && cnt_lo == prd_lo && !wr_enctl)
        |=> (en_lo == 2'd0 && irq_lo)); // R7

    AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (split && run_hi && tick && en_hi == 2'd2 && cnt_hi == prd_hi && !wr_cnt_hi)
        |=> (cnt_hi == '0 && irq_hi)); // R6
endmodule

bind split_timer stmr_checker #(.ADDR_W(ADDR_W)) i_stmr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .split    (arr_q[0]),
    .run_lo   (run_q[0]),
    .run_hi   (run_q[1]),
    .en_lo    (en_q[0]),
    .en_hi    (en_q[1]),
    .cnt_lo   (cnt_q[0]),
    .cnt_hi   (cnt_q[1]),
    .prd_lo   (prd_q[0]),
    .prd_hi   (prd_q[1]),
    .irq_lo   (irq_lo),
    .irq_hi   (irq_hi)
);

// File: tb/test_split_timer.sv
module test_split_timer;
    localparam int          ADDR_W = 8;
    localparam logic [31:0] ID_VAL = 32'h7143_0201;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_lo, irq_hi;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    split_timer #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VAL)) i_split_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); chk("R1 id", v, ID_VAL);
        rd(8'h10, v); chk("R1 cnt_lo", v, 0);
        rd(8'h14, v); chk("R1 cnt_hi", v, 0);
        rd(8'h18, v); chk("R1 prd_lo", v, 0);
        rd(8'h20, v); chk("R1 enctl", v, 0);
        rd(8'h24, v); chk("R1 arrctl", v, 0);
        chk("R1 irq", {30'd0, irq_hi, irq_lo}, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(8'h18, 32'h1234_5678); rd(8'h18, v); chk("R2 prd_lo", v, 32'h1234_5678);
        wr(8'h1C, 32'h9ABC_DEF0); rd(8'h1C, v); chk("R2 prd_hi", v, 32'h9ABC_DEF0);
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); chk("R2 enctl fields", v, 32'h00C0_00C0);
        wr(8'h20, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, v); chk("R2 arrctl fields", v, 32'h0000_000F);
        wr(8'h24, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h28, v); chk("R3 read 0x28", v, 0);
        rd(8'h04, v); chk("R3 read 0x04", v, 0);
        rd(8'h18, v); chk("R3 prd_lo kept", v, 32'h1234_5678);
        rd(8'h24, v); chk("R3 arrctl kept", v, 0);
        rd(8'h20, v); chk("R3 enctl kept", v, 0);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        wr(8'h10, 32'd5); rd(8'h10, v); chk("R5 write while held", v, 0);
        wr(8'h20, 32'h0000_0080);
        ticks(4); rd(8'h10, v); chk("R5 no count while held", v, 0);
    endtask

    task automatic t_split_count;
        logic [31:0] v;
        wr(8'h24, 32'h7);             // split, both halves running
        wr(8'h18, 32'd100); wr(8'h1C, 32'd100);
        wr(8'h20, 32'h0000_0080);     // lower periodic, upper off
        wr(8'h10, 32'd0);
        ticks(10);
        rd(8'h10, v); chk("R4 lower counted", v, 10);
        rd(8'h14, v); chk("R4 upper disabled holds", v, 0);
        repeat (3) @(negedge clk);
        rd(8'h10, v); chk("R4 no tick no count", v, 10);
        wr(8'h14, 32'd7); rd(8'h14, v); chk("R10 load disabled half", v, 7);
        ticks(2); rd(8'h14, v); chk("R4 upper still held", v, 7);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        wr(8'h18, 32'd3); wr(8'h10, 32'd0);
        @(negedge clk); tick = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            rd(8'h10, v); chk("R6 lower count", v, i % 4);
            chk("R6 lower irq", {31'd0, irq_lo}, (i % 4 == 0) ? 1 : 0);
        end
        tick = 1'b0;
        wr(8'h20, 32'h0080_0000);     // upper periodic, lower off
        wr(8'h1C, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFD);
        ticks(2); rd(8'h14, v); chk("R6 reach all ones", v, 32'hFFFF_FFFF);
        chk("R6 no irq before wrap", {31'd0, irq_hi}, 0);
        ticks(1); rd(8'h14, v); chk("R6 wrap to zero", v, 0);
        chk("R8 upper irq", {31'd0, irq_hi}, 1);
        chk("R8 lower irq quiet", {31'd0, irq_lo}, 0);
        @(negedge clk); chk("R6 upper irq one cycle", {31'd0, irq_hi}, 0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        wr(8'h20, 32'h0000_0040);     // lower one-shot
        wr(8'h18, 32'd2); wr(8'h10, 32'd0);
        @(negedge clk); tick = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h10, v); chk("R7 zero after match", v, 0);
        chk("R7 irq", {31'd0, irq_lo}, 1);
        repeat (2) @(negedge clk);
        tick = 1'b0;
        rd(8'h10, v); chk("R7 stays at zero", v, 0);
        chk("R7 irq gone", {31'd0, irq_lo}, 0);
        rd(8'h20, v); chk("R7 field cleared", v, 0);
    endtask

    task automatic t_split_alt;
        logic [31:0] v;
        wr(8'h24, 32'hF);
        wr(8'h20, 32'h0000_00C0);     // enable value 3 behaves periodic
        wr(8'h18, 32'd100); wr(8'h10, 32'd0);
        ticks(4); rd(8'h10, v); chk("R8 arrangement 3 split", v, 4);
        rd(8'h14, v); chk("R8 upper independent", v, 0);
    endtask

    task automatic t_joined;
        logic [31:0] v;
        wr(8'h20, 32'h0);
        wr(8'h24, 32'h3);             // joined, both running
        wr(8'h18, 32'd1); wr(8'h1C, 32'd1);
        wr(8'h10, 32'hFFFF_FFFE); wr(8'h14, 32'd0);
        wr(8'h20, 32'h0000_0080);     // lower field only
        ticks(2);
        rd(8'h10, v); chk("R9 lower wrapped", v, 0);
        rd(8'h14, v); chk("R9 carry into upper", v, 1);
        ticks(2);
        rd(8'h10, v); chk("R9 64-bit match lower", v, 0);
        rd(8'h14, v); chk("R9 64-bit match upper", v, 0);
        chk("R9 irq_lo", {31'd0, irq_lo}, 1);
        chk("R9 irq_hi low", {31'd0, irq_hi}, 0);
        wr(8'h24, 32'h1);             // upper held in reset
        ticks(3); rd(8'h10, v); chk("R9 needs both run bits", v, 0);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        wr(8'h24, 32'h7);
        wr(8'h20, 32'h0000_0080);
        wr(8'h18, 32'h1000);
        @(negedge clk); tick = 1'b1;
        wr(8'h10, 32'h50);
        rd(8'h10, v); chk("R10 write beats step", v, 32'h50);
        @(negedge clk);
        rd(8'h10, v); chk("R10 continue from written", v, 32'h51);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_unmapped();
        t_hold();
        t_split_count();
        t_periodic();
        t_oneshot();
        t_split_alt();
        t_joined();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule